// File: doc/BRIEF.md
# Two-Stage Watchdog Supervisor Timer

This block supervises software by counting cycles of a free-running clock derived from an on-chip RC oscillator, nominally 15 MHz. Software must restart the count regularly. If it does not, the count reaches the selected timeout. The block then raises a sticky interrupt flag and starts a fixed grace countdown. If software does not restart the watchdog before the grace window ends and resets are enabled, the block emits a fixed-width reset request. It also sets a cause flag that a system reset does not clear.

The interrupt timeout is picked by a two-bit select code. Each code step adds three powers of two to the interval, giving 2^12, 2^15, 2^18 or 2^21 cycles by default. At 15 MHz the shortest interval is about 0.273 ms, and the reset follows about 34 µs later. The control side is register-like: single-cycle strobes for writing the select code, restarting, clearing each flag and applying a synchronous system reset, plus level-type enables for the interrupt and the reset. The oscillator, bus decoding and reset distribution lie outside the block.

Top module: `wdog_supervisor`

## Requirements
- R1: After power-on reset (`por_n` low), `irq_flag_o`, `rst_flag_o`, `irq_o` and `rst_req_o` are 0 and `sel_o` is 0.
- R2: Select code s (0 to 3, shortest to longest) gives a timeout of 2^(BASE_LOG2 + STEP_LOG2·s) cycles. `irq_flag_o` is still 0 after that count minus one clock edges following the restart edge, and it is 1 after exactly that many edges.
- R3: `irq_o` is high while `irq_flag_o` is set and `irq_en_i` is 1, and low otherwise.
- R4: With `rst_en_i` = 1, `rst_req_o` rises exactly GRACE_CYCLES edges after the edge that sets `irq_flag_o`. It stays high for exactly PULSE_CYCLES cycles.
- R5: With `rst_en_i` = 0, the expiry of the grace window produces no reset request.
- R6: A restart strobe during the grace window clears both counts and cancels the reset. This includes a strobe on the very edge where the window would expire, because the restart takes priority.
- R7: `rst_flag_o` sets on the edge that starts a reset request. It is cleared only by `por_n` or by `clr_rst_flag_i`.
- R8: A select write before the interrupt timeout restarts the count, so the timeout is measured from the write edge.
- R9: A select write during the grace window updates `sel_o` but does not move the time of the reset request.
- R10: `irq_flag_o` stays set until `clr_irq_flag_i` is applied. A set on the same edge wins over the clear, and clearing the flag does not restart the count or cancel the grace window.
- R11: `sys_rst_i` returns `sel_o` to 0, zeros both counts and clears `irq_flag_o`, but leaves `rst_flag_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RC-derived counting clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| sys_rst_i | input | 1 | Synchronous system reset, active high |
| sel_wr_i | input | 1 | Write strobe for the timeout select code |
| sel_din_i | input | SEL_W | New timeout select code |
| irq_en_i | input | 1 | Interrupt request enable |
| rst_en_i | input | 1 | Reset request enable |
| restart_i | input | 1 | Restart strobe: clears both counts and leaves the grace window |
| clr_irq_flag_i | input | 1 | Clears the interrupt flag |
| clr_rst_flag_i | input | 1 | Clears the reset-cause flag |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Reset request pulse |
| irq_flag_o | output | 1 | Sticky interrupt-timeout flag |
| rst_flag_o | output | 1 | Sticky reset-cause flag |
| sel_o | output | SEL_W | Current timeout select code |

## Verification
The sharpest coincidence is a restart strobe on the same edge at which the grace window expires. The bench drives the strobe in the cycle just before the computed expiry edge. It judges the result by `rst_req_o` staying low and `rst_flag_o` staying clear through and beyond the window. A second coincidence is a flag clear landing on the timeout edge. The bench applies `clr_irq_flag_i` in the cycle before the computed timeout and expects the flag to read 1 afterwards.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    WD_RUN   = 1'b0,
    WD_GRACE = 1'b1
  } wd_phase_e;
endpackage

// File: rtl/wdog_divider.sv
// Main interval counter with one terminal-count tap per select code.
module wdog_divider #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             term
);
  localparam int NSEL = 1 << SEL_W;
  localparam int CW   = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);

  logic [CW-1:0]   cnt_q, cnt_d;
  logic            cnt_en;
  logic [NSEL-1:0] tap;

  // Each tap fires when the low bits for that interval are all ones.
  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    assign tap[g] = &cnt_q[BASE_LOG2 + STEP_LOG2 * g - 1:0];
  end

  assign term   = run && tap[sel];
  assign cnt_en = clr || run;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_grace.sv
// Fixed-length grace window counter.
module wdog_grace #(
  parameter int GRACE_CYCLES = 512
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic run,
  output logic expire
);
  localparam int GW = (GRACE_CYCLES > 1) ? $clog2(GRACE_CYCLES) : 1;
  localparam logic [GW-1:0] LAST = GW'(GRACE_CYCLES - 1);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire = run && (cnt_q == LAST);
  assign cnt_en = clr || run;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + GW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_rst_pulse.sv
// Stretches a one-cycle fire into a fixed-width reset request.
module wdog_rst_pulse #(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  output logic pulse
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [PW-1:0] left_q, left_d;
  logic          left_en;

  assign pulse   = (left_q != '0);
  assign left_en = fire || pulse;

  always_comb begin
    left_d = left_q;
    if (fire)       left_d = PW'(PULSE_CYCLES);
    else if (pulse) left_d = left_q - PW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int SEL_W        = 2,
  parameter int BASE_LOG2    = 12,
  parameter int STEP_LOG2    = 3,
  parameter int GRACE_CYCLES = 512,
  parameter int PULSE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_i,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_din_i,
  input  logic             irq_en_i,
  input  logic             rst_en_i,
  input  logic             restart_i,
  input  logic             clr_irq_flag_i,
  input  logic             clr_rst_flag_i,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             irq_flag_o,
  output logic             rst_flag_o,
  output logic [SEL_W-1:0] sel_o
);
  import wdog_pkg::*;

  wd_phase_e        phase_q, phase_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             irq_flag_q, irq_flag_d;
  logic             rst_flag_q, rst_flag_d;
  logic             div_clr, div_term;
  logic             grace_clr, grace_exp;
  logic             fire;

  wdog_divider #(
    .SEL_W    (SEL_W),
    .BASE_LOG2(BASE_LOG2),
    .STEP_LOG2(STEP_LOG2)
  ) u_div (
    .clk  (clk),
    .por_n(por_n),
    .clr  (div_clr),
    .run  (phase_q == WD_RUN),
    .sel  (sel_q),
    .term (div_term)
  );

  wdog_grace #(
    .GRACE_CYCLES(GRACE_CYCLES)
  ) u_grace (
    .clk   (clk),
    .por_n (por_n),
    .clr   (grace_clr),
    .run   (phase_q == WD_GRACE),
    .expire(grace_exp)
  );

  wdog_rst_pulse #(
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_pulse (
    .clk  (clk),
    .por_n(por_n),
    .fire (fire),
    .pulse(rst_req_o)
  );

  always_comb begin
    phase_d    = phase_q;
    sel_d      = sel_q;
    irq_flag_d = irq_flag_q;
    rst_flag_d = rst_flag_q;
    div_clr    = 1'b0;
    grace_clr  = 1'b0;
    fire       = 1'b0;

    if (sel_wr_i)       sel_d      = sel_din_i;
    if (clr_irq_flag_i) irq_flag_d = 1'b0;
    if (clr_rst_flag_i) rst_flag_d = 1'b0;

    unique case (phase_q)
      WD_RUN: begin
        if (restart_i) begin
          div_clr = 1'b1;
        end else if (div_term) begin
          irq_flag_d = 1'b1;
          phase_d    = WD_GRACE;
          div_clr    = 1'b1;
          grace_clr  = 1'b1;
        end else if (sel_wr_i) begin
          div_clr = 1'b1;
        end
      end
      WD_GRACE: begin
        if (restart_i) begin
          phase_d   = WD_RUN;
          div_clr   = 1'b1;
          grace_clr = 1'b1;
        end else if (grace_exp) begin
          phase_d   = WD_RUN;
          div_clr   = 1'b1;
          grace_clr = 1'b1;
          if (rst_en_i) begin
            fire       = 1'b1;
            rst_flag_d = 1'b1;
          end
        end
      end
      default: phase_d = WD_RUN;
    endcase

    if (sys_rst_i) begin
      phase_d    = WD_RUN;
      sel_d      = '0;
      irq_flag_d = 1'b0;
      div_clr    = 1'b1;
      grace_clr  = 1'b1;
      fire       = 1'b0;
      rst_flag_d = rst_flag_q & ~clr_rst_flag_i;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase_q    <= WD_RUN;
      sel_q      <= '0;
      irq_flag_q <= 1'b0;
      rst_flag_q <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      sel_q      <= sel_d;
      irq_flag_q <= irq_flag_d;
      rst_flag_q <= rst_flag_d;
    end
  end

  assign irq_flag_o = irq_flag_q;
  assign rst_flag_o = rst_flag_q;
  assign sel_o      = sel_q;
  assign irq_o      = irq_flag_q & irq_en_i;
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_i,
  input logic             rst_en_i,
  input logic             restart_i,
  input logic             clr_irq_flag_i,
  input logic             clr_rst_flag_i,
  input logic             rst_req_o,
  input logic             irq_flag_o,
  input logic             rst_flag_o,
  input logic [SEL_W-1:0] sel_o
);
  // R4: a reset request lasts more than one cycle
  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req_o) |=> rst_req_o);

  // R5: a reset request only starts when the reset enable was set
  assert_needs_enable_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req_o) |-> $past(rst_en_i));

  // R6: a restart on the deciding edge forbids a new reset request
  assert_restart_wins_R6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req_o) |-> !$past(restart_i) && !$past(sys_rst_i));

  // R7: the cause flag accompanies every new reset request
  assert_cause_flag_R7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req_o) |-> rst_flag_o);

  // R7: the cause flag only falls on its own clear
  assert_cause_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
    rst_flag_o && !clr_rst_flag_i |=> rst_flag_o);

  // R10: the interrupt flag is sticky
  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
    irq_flag_o && !clr_irq_flag_i && !sys_rst_i |=> irq_flag_o);

  // R11: system reset restores the shortest interval
  assert_sel_default_R11: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_i |=> sel_o == '0);
endmodule

bind wdog_supervisor wdog_supervisor_chk #(.SEL_W(SEL_W)) u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .sys_rst_i     (sys_rst_i),
  .rst_en_i      (rst_en_i),
  .restart_i     (restart_i),
  .clr_irq_flag_i(clr_irq_flag_i),
  .clr_rst_flag_i(clr_rst_flag_i),
  .rst_req_o     (rst_req_o),
  .irq_flag_o    (irq_flag_o),
  .rst_flag_o    (rst_flag_o),
  .sel_o         (sel_o)
);

// File: tb/wdog_supervisor_tb.sv
`timescale 1ns/1ps
module wdog_supervisor_tb;
  localparam int TB_SEL_W = 2;
  localparam int TB_BASE  = 4;
  localparam int TB_STEP  = 2;
  localparam int TB_GRACE = 8;
  localparam int TB_PULSE = 4;

  // {sel[1:0], irq_en}
  localparam logic [2:0] VEC [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b110, 3'b101};

  logic clk = 1'b0;
  logic por_n, sys_rst, sel_wr, irq_en, rst_en, restart, clr_irq, clr_rst;
  logic [TB_SEL_W-1:0] sel_din;
  logic irq, rst_req, irq_flag, rst_flag;
  logic [TB_SEL_W-1:0] sel_q;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  wdog_supervisor #(
    .SEL_W(TB_SEL_W), .BASE_LOG2(TB_BASE), .STEP_LOG2(TB_STEP),
    .GRACE_CYCLES(TB_GRACE), .PULSE_CYCLES(TB_PULSE)
  ) u_dut (
    .clk(clk), .por_n(por_n), .sys_rst_i(sys_rst), .sel_wr_i(sel_wr),
    .sel_din_i(sel_din), .irq_en_i(irq_en), .rst_en_i(rst_en),
    .restart_i(restart), .clr_irq_flag_i(clr_irq), .clr_rst_flag_i(clr_rst),
    .irq_o(irq), .rst_req_o(rst_req), .irq_flag_o(irq_flag),
    .rst_flag_o(rst_flag), .sel_o(sel_q)
  );

  function automatic int lim(input int s);
    return 1 << (TB_BASE + TB_STEP * s);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Restart, write select, set enables; optionally clear the cause flag.
  task automatic prep(input int s, input logic ie, input logic re, input logic clr_cause);
    restart = 1'b1; sel_wr = 1'b1; sel_din = TB_SEL_W'(s);
    clr_irq = 1'b1; clr_rst = clr_cause; irq_en = ie; rst_en = re;
    cyc(1);
    restart = 1'b0; sel_wr = 1'b0; clr_irq = 1'b0; clr_rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    por_n = 1'b0; sys_rst = 1'b0; sel_wr = 1'b0; sel_din = '0; irq_en = 1'b0;
    rst_en = 1'b0; restart = 1'b0; clr_irq = 1'b0; clr_rst = 1'b0;
    cyc(3);
    por_n = 1'b1;
    cyc(1);
    // R1: reset state
    chk("R1 irq_flag", irq_flag, 0);
    chk("R1 rst_flag", rst_flag, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sel", sel_q, 0);

    // R2 / R3: vector table over select codes and interrupt enable
    for (int i = 0; i < 6; i++) begin
      int  s;
      logic ie;
      s  = int'(VEC[i][2:1]);
      ie = VEC[i][0];
      prep(s, ie, 1'b0, 1'b1);
      cyc(lim(s) - 1);
      chk("R2 flag before timeout", irq_flag, 0);
      chk("R3 irq before timeout", irq, 0);
      cyc(1);
      chk("R2 flag at timeout", irq_flag, 1);
      chk("R3 irq gated by enable", irq, int'(ie));
    end

    // R4 / R7: full path to reset request
    prep(0, 1'b1, 1'b1, 1'b1);
    cyc(lim(0));
    chk("R4 flag set", irq_flag, 1);
    cyc(TB_GRACE - 1);
    chk("R4 no request early", rst_req, 0);
    chk("R7 no cause early", rst_flag, 0);
    cyc(1);
    chk("R4 request rises", rst_req, 1);
    chk("R7 cause set", rst_flag, 1);
    cyc(TB_PULSE - 1);
    chk("R4 request last cycle", rst_req, 1);
    cyc(1);
    chk("R4 request ends", rst_req, 0);
    chk("R7 cause survives", rst_flag, 1);

    // R11: system reset keeps cause flag, restores select
    prep(3, 1'b0, 1'b0, 1'b0);
    chk("R11 sel written", sel_q, 3);
    sys_rst = 1'b1;
    cyc(1);
    sys_rst = 1'b0;
    chk("R11 sel default", sel_q, 0);
    chk("R11 irq flag cleared", irq_flag, 0);
    chk("R11 cause kept", rst_flag, 1);
    cyc(lim(0) - 1);
    chk("R11 count zeroed early", irq_flag, 0);
    cyc(1);
    chk("R11 count zeroed timeout", irq_flag, 1);

    // R7: software clear of the cause flag
    clr_rst = 1'b1;
    cyc(1);
    clr_rst = 1'b0;
    chk("R7 cause cleared", rst_flag, 0);

    // R5: reset disabled
    begin
      bit seen;
      seen = 1'b0;
      prep(0, 1'b0, 1'b0, 1'b1);
      cyc(lim(0));
      for (int k = 0; k < TB_GRACE + TB_PULSE + 4; k++) begin
        cyc(1);
        if (rst_req) seen = 1'b1;
      end
      chk("R5 no request when disabled", int'(seen), 0);
      chk("R5 no cause when disabled", rst_flag, 0);
    end

    // R6: restart mid-window
    prep(0, 1'b0, 1'b1, 1'b1);
    cyc(lim(0) + 3);
    restart = 1'b1;
    cyc(1);
    restart = 1'b0;
    cyc(TB_GRACE);
    chk("R6 mid-window restart", rst_req, 0);
    chk("R6 mid-window cause", rst_flag, 0);

    // R6: restart on the expiry edge itself
    prep(0, 1'b0, 1'b1, 1'b1);
    cyc(lim(0));
    cyc(TB_GRACE - 1);
    restart = 1'b1;
    cyc(1);
    restart = 1'b0;
    chk("R6 expiry-edge restart", rst_req, 0);
    chk("R6 expiry-edge cause", rst_flag, 0);
    cyc(2);
    chk("R6 expiry-edge later", rst_req, 0);

    // R8: select write before timeout restarts the count
    prep(0, 1'b0, 1'b0, 1'b1);
    cyc(5);
    sel_wr = 1'b1; sel_din = '0;
    cyc(1);
    sel_wr = 1'b0;
    cyc(lim(0) - 1);
    chk("R8 timeout moved", irq_flag, 0);
    cyc(1);
    chk("R8 timeout from write", irq_flag, 1);

    // R9: select write in the grace window does not move the reset
    prep(0, 1'b0, 1'b1, 1'b1);
    cyc(lim(0));
    cyc(2);
    sel_wr = 1'b1; sel_din = 2'd1;
    cyc(1);
    sel_wr = 1'b0;
    chk("R9 sel updated", sel_q, 1);
    cyc(TB_GRACE - 4);
    chk("R9 no request early", rst_req, 0);
    cyc(1);
    chk("R9 request on time", rst_req, 1);

    // R10: clearing the flag does not restart or cancel
    prep(0, 1'b0, 1'b1, 1'b1);
    cyc(lim(0));
    clr_irq = 1'b1;
    cyc(1);
    clr_irq = 1'b0;
    chk("R10 flag cleared", irq_flag, 0);
    cyc(TB_GRACE - 2);
    chk("R10 no request early", rst_req, 0);
    cyc(1);
    chk("R10 request still comes", rst_req, 1);

    // R10: set beats clear on the timeout edge
    prep(0, 1'b0, 1'b0, 1'b1);
    cyc(lim(0) - 1);
    clr_irq = 1'b1;
    cyc(1);
    clr_irq = 1'b0;
    chk("R10 set wins over clear", irq_flag, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule